// File: doc/BRIEF.md
# RTC Sub-Second Increment Updater

This block turns one low-frequency oscillator measurement into the 24-bit value that a real-time clock adds to its sub-second counter on every tick. The measurement is a count of fast reference cycles spanning 32 periods of the slow oscillator. The block scales that count by a fixed constant over 256. It can then add a signed correction for the drift of a high-precision reference oscillator. It smooths the result with an equal-weight average against the value already held, and then raises an update request for the clock.

Each measurement arrives as a count with a one-cycle valid strobe. The drift enable and the drift offset are captured on that same strobe. The first sample after reset or after a re-arm skips the average, so the increment converges in one step. The increment leaves the block as a 16-bit low half and an upper half. The update request stays high until the controller marks the start of the next measurement sequence.

Top module: `rtc_subsec_updater`

## Requirements
- R1: While reset is asserted and after it is released, the increment reads zero, the update request is low, and the next sample is treated as a first sample.
- R2: The raw increment is floor(45813 × count / 256), computed without loss from a 24-bit count.
- R3: When the drift enable is high on the valid cycle, the new value is raw + floor(floor(raw/16) × floor(offset/8) / 32768), with the 32-bit offset taken as two's complement; when the enable is low, the new value is raw.
- R4: The first sample after reset or re-arm loads the new value's low 24 bits directly into the increment.
- R5: Each later sample loads bits [24:1] of (previous 24-bit increment + new value), that is, the floor of half the sum, kept to 24 bits.
- R6: The low-half output carries increment bits [15:0], and the high-half output carries bits [23:16].
- R7: A sample strobed in cycle c appears on the outputs from cycle c+3 onward. Back-to-back strobes are all accepted, in order.
- R8: The update request rises together with each new increment and stays high until a sequence-start pulse. If a sequence-start pulse and a new increment fall on the same cycle, the request stays set.
- R9: A re-arm pulse makes the next sample unfiltered, and it changes neither the increment nor the update request.
- R10: Without a valid strobe, changes on count, drift enable or offset leave the increment and the request unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rearm | input | 1 | Pulse: make the next sample unfiltered |
| seq_start | input | 1 | Pulse: a new measurement sequence begins, drops the update request |
| meas_valid | input | 1 | Strobe: count and drift inputs are valid |
| meas_count | input | 24 | Reference cycles counted over 32 slow periods |
| drift_en | input | 1 | Apply the drift correction to this sample |
| drift_ofs | input | 32 | Signed drift offset |
| inc_lo | output | 16 | Increment bits [15:0] |
| inc_hi | output | 8 | Increment bits [23:16] |
| upd_req | output | 1 | Update request to the real-time clock |

## Verification
The hardest cases to reach are the extremes of the drift product: a full-scale count multiplied by a large negative offset. That product drives the new value below zero, and the average must then wrap correctly to 24 bits. Directed samples pair the maximum count with offsets near both signed limits. Random offsets over the full 32-bit range cover the area in between. A back-to-back pair of strobes checks that the second sample is averaged against the first while both are still in the pipeline.

// File: rtl/subsec_pkg.sv
package subsec_pkg;
  localparam int unsigned DEF_CNT_W   = 24;
  localparam int unsigned DEF_SCALE_W = 17;
  localparam int unsigned DEF_SCALE   = 45813;
  localparam int unsigned DEF_FRAC_SH = 8;
  localparam int unsigned DEF_OFS_W   = 32;
  localparam int unsigned DEF_INC_W   = 24;
  localparam int unsigned DEF_HALF_W  = 16;
  localparam int unsigned RAW_DROP    = 4;
  localparam int unsigned OFS_DROP    = 3;
  localparam int unsigned PROD_DROP   = 15;
endpackage

// File: rtl/subsec_rst_sync.sv
module subsec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= stg_d;
  end

  assign rst_n_sync = stg_q[1];
endmodule

// File: rtl/subsec_scale.sv
module subsec_scale #(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned SCALE_W = 17,
  parameter int unsigned SCALE   = 45813,
  parameter int unsigned FRAC_SH = 8,
  parameter int unsigned OFS_W   = 32,
  localparam int unsigned PROD_W = CNT_W + SCALE_W,
  localparam int unsigned RAW_W  = PROD_W - FRAC_SH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CNT_W-1:0] in_count,
  input  logic             in_drift_en,
  input  logic [OFS_W-1:0] in_drift_ofs,
  output logic             out_valid,
  output logic [RAW_W-1:0] out_raw,
  output logic             out_drift_en,
  output logic [OFS_W-1:0] out_drift_ofs
);
  logic [PROD_W-1:0] prod_c;
  logic              vld_d;
  logic [RAW_W-1:0]  raw_d;
  logic              en_d;
  logic [OFS_W-1:0]  ofs_d;
  logic              ld_en;

  assign prod_c = PROD_W'(SCALE) * PROD_W'(in_count);
  assign ld_en  = in_valid;

  always_comb begin
    vld_d = in_valid;
    raw_d = out_raw;
    en_d  = out_drift_en;
    ofs_d = out_drift_ofs;
    if (ld_en) begin
      raw_d = prod_c[PROD_W-1:FRAC_SH];
      en_d  = in_drift_en;
      ofs_d = in_drift_ofs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_raw       <= '0;
      out_drift_en  <= 1'b0;
      out_drift_ofs <= '0;
    end else begin
      out_valid     <= vld_d;
      out_raw       <= raw_d;
      out_drift_en  <= en_d;
      out_drift_ofs <= ofs_d;
    end
  end
endmodule

// File: rtl/subsec_drift.sv
module subsec_drift #(
  parameter int unsigned RAW_W     = 33,
  parameter int unsigned OFS_W     = 32,
  parameter int unsigned RAW_DROP  = 4,
  parameter int unsigned OFS_DROP  = 3,
  parameter int unsigned PROD_DROP = 15,
  localparam int unsigned RS_W   = RAW_W - RAW_DROP + 1,
  localparam int unsigned OS_W   = OFS_W - OFS_DROP,
  localparam int unsigned MUL_W  = RS_W + OS_W,
  localparam int unsigned CORR_W = MUL_W - PROD_DROP,
  localparam int unsigned NEW_W  = CORR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [RAW_W-1:0] in_raw,
  input  logic             in_drift_en,
  input  logic [OFS_W-1:0] in_drift_ofs,
  output logic             out_valid,
  output logic [NEW_W-1:0] out_new
);
  logic signed [RS_W-1:0]  raw_s;
  logic signed [OS_W-1:0]  ofs_s;
  logic signed [MUL_W-1:0] mul_s;
  logic [CORR_W-1:0]       corr;
  logic [NEW_W-1:0]        raw_ext;
  logic [NEW_W-1:0]        corr_ext;
  logic [NEW_W-1:0]        new_d;

  assign raw_s    = $signed({1'b0, in_raw[RAW_W-1:RAW_DROP]});
  assign ofs_s    = $signed(in_drift_ofs[OFS_W-1:OFS_DROP]);
  assign mul_s    = raw_s * ofs_s;
  assign corr     = mul_s[MUL_W-1:PROD_DROP];
  assign raw_ext  = {{(NEW_W-RAW_W){1'b0}}, in_raw};
  assign corr_ext = {{(NEW_W-CORR_W){corr[CORR_W-1]}}, corr};

  always_comb begin
    new_d = out_new;
    if (in_valid) begin
      new_d = in_drift_en ? (raw_ext + corr_ext) : raw_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_new   <= '0;
    end else begin
      out_valid <= in_valid;
      out_new   <= new_d;
    end
  end
endmodule

// File: rtl/subsec_filter.sv
module subsec_filter #(
  parameter int unsigned NEW_W = 45,
  parameter int unsigned INC_W = 24,
  localparam int unsigned SUM_W = NEW_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [NEW_W-1:0] in_new,
  input  logic             rearm,
  input  logic             seq_start,
  output logic [INC_W-1:0] inc,
  output logic             req
);
  logic             first_q;
  logic             first_d;
  logic [INC_W-1:0] inc_d;
  logic             req_d;
  logic [SUM_W-1:0] old_ext;
  logic [SUM_W-1:0] new_ext;
  logic [SUM_W-1:0] sum;

  assign old_ext = {{(SUM_W-INC_W){1'b0}}, inc};
  assign new_ext = {in_new[NEW_W-1], in_new};
  assign sum     = old_ext + new_ext;

  always_comb begin
    inc_d   = inc;
    first_d = first_q;
    req_d   = req;
    if (seq_start) req_d = 1'b0;
    if (in_valid) begin
      inc_d   = first_q ? in_new[INC_W-1:0] : sum[INC_W:1];
      first_d = 1'b0;
      req_d   = 1'b1;
    end
    if (rearm) first_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc     <= '0;
      first_q <= 1'b1;
      req     <= 1'b0;
    end else begin
      inc     <= inc_d;
      first_q <= first_d;
      req     <= req_d;
    end
  end
endmodule

// File: rtl/rtc_subsec_updater.sv
module rtc_subsec_updater
  import subsec_pkg::*;
#(
  parameter int unsigned CNT_W   = DEF_CNT_W,
  parameter int unsigned SCALE_W = DEF_SCALE_W,
  parameter int unsigned SCALE   = DEF_SCALE,
  parameter int unsigned FRAC_SH = DEF_FRAC_SH,
  parameter int unsigned OFS_W   = DEF_OFS_W,
  parameter int unsigned INC_W   = DEF_INC_W,
  parameter int unsigned HALF_W  = DEF_HALF_W,
  localparam int unsigned RAW_W  = CNT_W + SCALE_W - FRAC_SH,
  localparam int unsigned NEW_W  = (RAW_W - RAW_DROP + 1) + (OFS_W - OFS_DROP) - PROD_DROP + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rearm,
  input  logic                    seq_start,
  input  logic                    meas_valid,
  input  logic [CNT_W-1:0]        meas_count,
  input  logic                    drift_en,
  input  logic [OFS_W-1:0]        drift_ofs,
  output logic [HALF_W-1:0]       inc_lo,
  output logic [INC_W-HALF_W-1:0] inc_hi,
  output logic                    upd_req
);
  logic             rst_n_i;
  logic             s1_valid;
  logic [RAW_W-1:0] s1_raw;
  logic             s1_en;
  logic [OFS_W-1:0] s1_ofs;
  logic             s2_valid;
  logic [NEW_W-1:0] s2_new;
  logic [INC_W-1:0] inc;

  subsec_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  subsec_scale #(
    .CNT_W(CNT_W), .SCALE_W(SCALE_W), .SCALE(SCALE),
    .FRAC_SH(FRAC_SH), .OFS_W(OFS_W)
  ) u_scale (
    .clk           (clk),
    .rst_n         (rst_n_i),
    .in_valid      (meas_valid),
    .in_count      (meas_count),
    .in_drift_en   (drift_en),
    .in_drift_ofs  (drift_ofs),
    .out_valid     (s1_valid),
    .out_raw       (s1_raw),
    .out_drift_en  (s1_en),
    .out_drift_ofs (s1_ofs)
  );

  subsec_drift #(
    .RAW_W(RAW_W), .OFS_W(OFS_W), .RAW_DROP(RAW_DROP),
    .OFS_DROP(OFS_DROP), .PROD_DROP(PROD_DROP)
  ) u_drift (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .in_valid     (s1_valid),
    .in_raw       (s1_raw),
    .in_drift_en  (s1_en),
    .in_drift_ofs (s1_ofs),
    .out_valid    (s2_valid),
    .out_new      (s2_new)
  );

  subsec_filter #(
    .NEW_W(NEW_W), .INC_W(INC_W)
  ) u_filter (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .in_valid  (s2_valid),
    .in_new    (s2_new),
    .rearm     (rearm),
    .seq_start (seq_start),
    .inc       (inc),
    .req       (upd_req)
  );

  assign inc_lo = inc[HALF_W-1:0];
  assign inc_hi = inc[INC_W-1:HALF_W];
endmodule

// File: rtl/rtc_subsec_updater_chk.sv
module rtc_subsec_updater_chk #(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned HI_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seq_start,
  input logic              meas_valid,
  input logic              rearm,
  input logic [HALF_W-1:0] inc_lo,
  input logic [HI_W-1:0]   inc_hi,
  input logic              upd_req
);
  AST_REQ_FOLLOWS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |=> ##2 upd_req); // R8

  AST_REQ_DROPS_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start && !$past(meas_valid, 2)) |=> !upd_req); // R8

  AST_INC_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(meas_valid, 2) |=> $stable({inc_hi, inc_lo})); // R10

  AST_REQ_RISE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_req) |-> $past(meas_valid, 3)); // R7

  AST_REARM_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm && !upd_req && !$past(meas_valid, 2)) |=> !upd_req); // R9
endmodule

bind rtc_subsec_updater rtc_subsec_updater_chk #(
  .HALF_W(HALF_W), .HI_W(INC_W - HALF_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_i),
  .seq_start  (seq_start),
  .meas_valid (meas_valid),
  .rearm      (rearm),
  .inc_lo     (inc_lo),
  .inc_hi     (inc_hi),
  .upd_req    (upd_req)
);

// File: tb/rtc_subsec_updater_tb.sv
module rtc_subsec_updater_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rearm, seq_start, meas_valid, drift_en;
  logic [23:0] meas_count;
  logic [31:0] drift_ofs;
  logic [15:0] inc_lo;
  logic [7:0]  inc_hi;
  logic        upd_req;

  int n_chk = 0;
  int n_fail = 0;
  logic [23:0] m_inc;
  logic        m_first;

  always #10 clk = ~clk;

  rtc_subsec_updater u_dut (
    .clk(clk), .rst_n(rst_n), .rearm(rearm), .seq_start(seq_start),
    .meas_valid(meas_valid), .meas_count(meas_count), .drift_en(drift_en),
    .drift_ofs(drift_ofs), .inc_lo(inc_lo), .inc_hi(inc_hi), .upd_req(upd_req)
  );

  function automatic longint new_val(input logic [23:0] cnt, input logic en,
                                     input logic [31:0] ofs);
    longint raw, rs, os, corr;
    raw = (longint'(45813) * longint'(cnt)) >>> 8;
    if (!en) return raw;
    rs   = raw >>> 4;
    os   = longint'($signed(ofs)) >>> 3;
    corr = (rs * os) >>> 15;
    return raw + corr;
  endfunction

  task automatic check(input string req, input longint got, input longint exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic model(input logic [23:0] cnt, input logic en, input logic [31:0] ofs);
    longint nv, s;
    nv = new_val(cnt, en, ofs);
    if (m_first) m_inc = nv[23:0];
    else begin
      s = longint'(m_inc) + nv;
      s = s >>> 1;
      m_inc = s[23:0];
    end
    m_first = 1'b0;
  endtask

  task automatic sample(input logic [23:0] cnt, input logic en, input logic [31:0] ofs,
                        input string req);
    @(negedge clk);
    meas_valid = 1'b1; meas_count = cnt; drift_en = en; drift_ofs = ofs;
    @(negedge clk);
    meas_valid = 1'b0;
    meas_count = ~cnt; drift_en = ~en; drift_ofs = ~ofs;
    @(negedge clk);
    check({req, " R7 early"}, {inc_hi, inc_lo}, m_inc);
    @(negedge clk);
    model(cnt, en, ofs);
    check(req, {inc_hi, inc_lo}, m_inc);
    check({req, " R8 req"}, upd_req, 1);
  endtask

  task automatic pulse_start;
    @(negedge clk); seq_start = 1'b1;
    @(negedge clk); seq_start = 1'b0;
    check("R8 cleared", upd_req, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; rearm = 0; seq_start = 0; meas_valid = 0;
    meas_count = 0; drift_en = 0; drift_ofs = 0;
    m_inc = 0; m_first = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 inc during reset", {inc_hi, inc_lo}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 inc after reset", {inc_hi, inc_lo}, 0);
    check("R1 req after reset", upd_req, 0);

    // R2 R4: first sample loads raw scaled value directly
    sample(24'd1000, 1'b0, 32'd0, "R4 first");
    check("R2 raw", {inc_hi, inc_lo}, (45813 * 1000) / 256);
    check("R6 lo half", inc_lo, m_inc[15:0]);
    check("R6 hi half", inc_hi, m_inc[23:16]);
    // R5 averaging
    sample(24'd3000, 1'b0, 32'd0, "R5 average");
    pulse_start();
    // R10 idle inputs ignored
    @(negedge clk); meas_count = 24'hABCDEF; drift_en = 1; drift_ofs = 32'h7;
    repeat (4) @(negedge clk);
    check("R10 inc idle", {inc_hi, inc_lo}, m_inc);
    check("R10 req idle", upd_req, 0);
    // R9 rearm
    @(negedge clk); rearm = 1; @(negedge clk); rearm = 0;
    repeat (3) @(negedge clk);
    check("R9 rearm inc", {inc_hi, inc_lo}, m_inc);
    check("R9 rearm req", upd_req, 0);
    m_first = 1'b1;
    sample(24'd360, 1'b0, 32'd0, "R9 unfiltered");
    // R3 drift corners
    sample(24'hFFFFFF, 1'b1, 32'h7FFFFFFF, "R3 max pos");
    sample(24'hFFFFFF, 1'b1, 32'h80000000, "R3 max neg");
    sample(24'h000000, 1'b1, 32'h80000000, "R3 zero count");
    sample(24'h123456, 1'b1, 32'hFFFFFFF9, "R3 small neg");
    // R8 start and new result on the same cycle: set wins
    @(negedge clk); meas_valid = 1; meas_count = 24'd777; drift_en = 0;
    @(negedge clk); meas_valid = 0;
    @(negedge clk); seq_start = 1;
    @(negedge clk); seq_start = 0;
    model(24'd777, 1'b0, 32'd0);
    check("R8 set wins", upd_req, 1);
    check("R8 set wins inc", {inc_hi, inc_lo}, m_inc);
    // R7 back-to-back strobes
    @(negedge clk); meas_valid = 1; meas_count = 24'd50000; drift_en = 1; drift_ofs = 32'hFFF00000;
    @(negedge clk); meas_count = 24'd90000; drift_en = 0;
    @(negedge clk); meas_valid = 0;
    repeat (2) @(negedge clk);
    model(24'd50000, 1'b1, 32'hFFF00000);
    model(24'd90000, 1'b0, 32'd0);
    check("R7 back-to-back", {inc_hi, inc_lo}, m_inc);
    // random samples
    for (int i = 0; i < 200; i++) begin
      logic [23:0] c; logic e; logic [31:0] o;
      c = 24'($urandom); e = 1'($urandom); o = $urandom;
      if (($urandom % 16) == 0) begin
        @(negedge clk); rearm = 1; @(negedge clk); rearm = 0;
        m_first = 1'b1;
      end
      sample(c, e, o, e ? "R3 random" : "R5 random");
      if (($urandom % 4) == 0) pulse_start();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule